// File: doc/BRIEF.md
# Run-Length Expanding Byte Receiver

This block sits on the reverse path of a parallel port, between the byte receiver and the 16-byte receive FIFO. Each incoming byte carries a tag that marks it as a command or as data. A command byte whose top bit is clear is a run-length count. The block captures that count and does not pass it on. It then writes the data byte that follows into the FIFO count+1 times. A command byte whose top bit is set is a channel address. It is forwarded with its command tag, as are plain data bytes that have no count pending.

The input side is a valid/ready byte stream with a command tag. The output side is a FIFO write strobe with tag and byte, plus a full flag from the FIFO. A full FIFO holds off both the input and any expansion in progress. When the FIFO has room again, the expansion resumes where it stopped, so no copy is lost.

Top module: `rle_expander`

## Requirements
- R1: After reset, `in_ready` is 1 while `fifo_full` is 0, no write is issued while `in_valid` is 0, and no count is pending.
- R2: A data byte (`in_is_cmd`=0) accepted with no count pending is written once, in its acceptance cycle, with `wr_is_cmd`=0 and the same byte value.
- R3: A command byte with bit 7 = 1 (channel address) is written in its acceptance cycle with `wr_is_cmd`=1 and the byte unchanged.
- R4: A command byte with bit 7 = 0 (run count) is never written; its bits 6:0 become the pending count.
- R5: A data byte accepted with pending count N (0..127) produces exactly N+1 consecutive data writes of that byte. The first write is in the acceptance cycle, and the count is consumed.
- R6: `in_ready` is 0 while an expansion still has copies to write and whenever `fifo_full` is 1.
- R7: No write is issued while `fifo_full` is 1; an expansion pauses then and resumes afterwards without dropping or adding copies.
- R8: A second run-count command replaces the pending count; a channel-address command discards any pending count.
- R9: Reset discards a pending count and aborts an expansion in progress; the next data byte after reset is written once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Incoming byte is present |
| in_is_cmd | input | 1 | Incoming byte is a command (1) or data (0) |
| in_byte | input | DATA_W | Incoming byte |
| in_ready | output | 1 | Block accepts the byte this cycle |
| fifo_full | input | 1 | Receive FIFO cannot take a write |
| wr_en | output | 1 | FIFO write strobe |
| wr_is_cmd | output | 1 | Tag stored with the written byte |
| wr_byte | output | DATA_W | Byte written to the FIFO |

## Verification
The bound checker checks several rules on every cycle. No write happens into a full FIFO, and input is refused while the FIFO is full. A run count is never written. Accepted data and address bytes show up on the write port in the same cycle with the right tag. Every non-full cycle of an expansion produces a data write. Only the bench's scenarios can show that the number of copies is exactly N+1 for counts such as 0, 1 and 127. They also show that a pause under backpressure loses nothing, and how pending counts are replaced or cleared by later commands and by reset.

// File: rtl/rle_pkg.sv
package rle_pkg;

   typedef enum logic [1:0] {
      KIND_DATA = 2'd0,
      KIND_ADDR = 2'd1,
      KIND_RUN  = 2'd2
   } byte_kind_e;

endpackage

// File: rtl/rle_classify.sv
module rle_classify
   import rle_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter bit RUN_ON_MSB_LOW  = 1'b1
) (
   input  logic              is_cmd,
   input  logic [DATA_W-1:0] value,
   output byte_kind_e        kind
);
   localparam int MSB = DATA_W - 1;

   logic run_flag;

   generate
      if (RUN_ON_MSB_LOW) begin : g_run_low
         assign run_flag = ~value[MSB];
      end else begin : g_run_high
         assign run_flag = value[MSB];
      end
   endgenerate

   always_comb begin
      if (!is_cmd)       kind = KIND_DATA;
      else if (run_flag) kind = KIND_RUN;
      else               kind = KIND_ADDR;
   end
endmodule

// File: rtl/rle_count_hold.sv
module rle_count_hold #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             clear,
   input  logic [CNT_W-1:0] load_val,
   output logic             pending,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         count   <= '0;
      end else if (load) begin
         pending <= 1'b1;
         count   <= load_val;
      end else if (clear) begin
         pending <= 1'b0;
         count   <= '0;
      end
   end
endmodule

// File: rtl/rle_repeat_engine.sv
module rle_repeat_engine #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  extra,
   input  logic [DATA_W-1:0] start_byte,
   input  logic              stall,
   output logic              busy,
   output logic [DATA_W-1:0] held_byte
);
   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         remain    <= '0;
         held_byte <= '0;
      end else if (start) begin
         busy      <= (extra != '0);
         remain    <= extra;
         held_byte <= start_byte;
      end else if (busy && !stall) begin
         remain <= remain - 1'b1;
         busy   <= (remain != {{(CNT_W-1){1'b0}}, 1'b1});
      end
   end
endmodule

// File: rtl/rle_expander.sv
module rle_expander
   import rle_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter bit RUN_ON_MSB_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_is_cmd,
   input  logic [DATA_W-1:0] in_byte,
   output logic              in_ready,
   input  logic              fifo_full,
   output logic              wr_en,
   output logic              wr_is_cmd,
   output logic [DATA_W-1:0] wr_byte
);
   localparam int CNT_W = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("rle_expander: DATA_W must be at least 2");
      end
   endgenerate

   byte_kind_e        kind;
   logic              accept;
   logic              pending;
   logic [CNT_W-1:0]  count;
   logic              busy;
   logic [DATA_W-1:0] held_byte;
   logic              start;

   rle_classify #(.DATA_W(DATA_W), .RUN_ON_MSB_LOW(RUN_ON_MSB_LOW)) i_classify (
      .is_cmd (in_is_cmd),
      .value  (in_byte),
      .kind   (kind)
   );

   assign in_ready = !busy && !fifo_full;
   assign accept   = in_valid && in_ready;
   assign start    = accept && (kind == KIND_DATA) && pending;

   rle_count_hold #(.CNT_W(CNT_W)) i_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept && (kind == KIND_RUN)),
      .clear    (accept && (kind != KIND_RUN)),
      .load_val (in_byte[CNT_W-1:0]),
      .pending  (pending),
      .count    (count)
   );

   rle_repeat_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .extra      (count),
      .start_byte (in_byte),
      .stall      (fifo_full),
      .busy       (busy),
      .held_byte  (held_byte)
   );

   always_comb begin
      wr_en     = 1'b0;
      wr_is_cmd = 1'b0;
      wr_byte   = in_byte;
      if (busy) begin
         wr_en   = !fifo_full;
         wr_byte = held_byte;
      end else if (accept && (kind != KIND_RUN)) begin
         wr_en     = 1'b1;
         wr_is_cmd = (kind == KIND_ADDR);
      end
   end
endmodule

// File: rtl/rle_expander_chk.sv
module rle_expander_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_is_cmd,
   input logic [DATA_W-1:0] in_byte,
   input logic              in_ready,
   input logic              fifo_full,
   input logic              wr_en,
   input logic              wr_is_cmd,
   input logic [DATA_W-1:0] wr_byte
);
   AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !wr_en); // R7
   AST_NO_ACCEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !in_ready); // R6
   AST_RUN_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_is_cmd && !in_byte[DATA_W-1]) |-> !wr_en); // R4
   AST_ADDR_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_is_cmd && in_byte[DATA_W-1])
         |-> (wr_en && wr_is_cmd && wr_byte == in_byte)); // R3
   AST_DATA_FIRST_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_is_cmd)
         |-> (wr_en && !wr_is_cmd && wr_byte == in_byte)); // R2
   AST_EXPAND_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && !fifo_full) |-> (wr_en && !wr_is_cmd)); // R5
   AST_EXPAND_SAME_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && !fifo_full && !$past(in_ready) && !$past(fifo_full) && $past(rst_n))
         |-> (wr_byte == $past(wr_byte))); // R5
endmodule

bind rle_expander rle_expander_chk #(.DATA_W(DATA_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_is_cmd (in_is_cmd),
   .in_byte   (in_byte),
   .in_ready  (in_ready),
   .fifo_full (fifo_full),
   .wr_en     (wr_en),
   .wr_is_cmd (wr_is_cmd),
   .wr_byte   (wr_byte)
);

// File: tb/test_rle_expander.sv
module test_rle_expander;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_is_cmd = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       in_ready;
   logic       fifo_full = 1'b0;
   logic       wr_en;
   logic       wr_is_cmd;
   logic [7:0] wr_byte;

   int errors = 0;
   int checks = 0;
   int pend = -1;
   logic [8:0] exp_q[$];
   string      req_q[$];

   always #10 clk = ~clk;

   rle_expander i_rle_expander (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_cmd(in_is_cmd),
      .in_byte(in_byte), .in_ready(in_ready), .fifo_full(fifo_full),
      .wr_en(wr_en), .wr_is_cmd(wr_is_cmd), .wr_byte(wr_byte)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // monitor: pops scoreboard on every write
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R4/R5 unexpected write", {wr_is_cmd, wr_byte}, 0);
         end else begin
            automatic logic [8:0] e = exp_q.pop_front();
            automatic string r = req_q.pop_front();
            check({wr_is_cmd, wr_byte} == e, r, {wr_is_cmd, wr_byte}, e);
         end
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         check(1'b0, "watchdog", cyc, 0);
         finish_run();
      end
   end

   task automatic push(input bit t, input logic [7:0] b, input string r);
      exp_q.push_back({t, b});
      req_q.push_back(r);
   endtask

   task automatic send(input bit cmd, input logic [7:0] b, input string r);
      if (cmd && !b[7]) pend = b[6:0];
      else if (cmd) begin push(1'b1, b, r); pend = -1; end
      else begin
         for (int i = 0; i < ((pend < 0) ? 1 : pend + 1); i++) push(1'b0, b, r);
         pend = -1;
      end
      @(posedge clk); #1;
      in_valid = 1'b1; in_is_cmd = cmd; in_byte = b;
      forever begin
         @(negedge clk);
         if (in_ready) break;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic drain(input string r);
      forever begin
         @(negedge clk);
         if (in_ready || fifo_full) break;
      end
      check(exp_q.size() == 0, r, exp_q.size(), 0);
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0;
      exp_q.delete(); req_q.delete(); pend = -1;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(in_ready === 1'b1, "R1 ready after reset", in_ready, 1);
      check(wr_en === 1'b0, "R1 no write after reset", wr_en, 0);

      send(1'b0, 8'h5A, "R2 plain data");
      send(1'b0, 8'h00, "R2 plain data zero");
      send(1'b1, 8'h83, "R3 address forward");
      send(1'b1, 8'hFF, "R3 address forward max");
      drain("R2 R3 all written");

      // count 0 -> one copy, count 1 -> two copies
      send(1'b1, 8'h00, "R4");
      send(1'b0, 8'h21, "R5 count 0");
      send(1'b1, 8'h01, "R4");
      send(1'b0, 8'h42, "R5 count 1");
      drain("R5 small counts drained");

      // expansion holds ready low
      send(1'b1, 8'h04, "R4");
      send(1'b0, 8'h11, "R5 count 4");
      @(negedge clk);
      check(in_ready === 1'b0, "R6 ready low while expanding", in_ready, 0);
      drain("R5 count 4 drained");

      // maximum count
      send(1'b1, 8'h7F, "R4");
      send(1'b0, 8'hEE, "R5 count 127");
      drain("R5 128 copies");

      // backpressure during expansion
      send(1'b1, 8'h0A, "R4");
      send(1'b0, 8'hC3, "R7 paused expansion");
      fifo_full = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(wr_en === 1'b0, "R7 no write while full", wr_en, 0);
         check(in_ready === 1'b0, "R6 ready low while full", in_ready, 0);
      end
      @(posedge clk); #1 fifo_full = 1'b0;
      drain("R7 no copy lost");

      // full while idle holds off input
      @(posedge clk); #1 fifo_full = 1'b1;
      fork
         send(1'b0, 8'h66, "R6 held data");
         begin
            for (int i = 0; i < 3; i++) begin
               @(negedge clk);
               check(in_ready === 1'b0 && wr_en === 1'b0, "R6 idle full holds input", in_ready, 0);
            end
            @(posedge clk); #1 fifo_full = 1'b0;
         end
      join
      drain("R6 held data written");

      // replacement and clearing of pending count
      send(1'b1, 8'h09, "R4");
      send(1'b1, 8'h02, "R4");
      send(1'b0, 8'hA5, "R8 second count replaces");
      drain("R8 replace drained");
      send(1'b1, 8'h07, "R4");
      send(1'b1, 8'h85, "R8 address clears");
      send(1'b0, 8'h3C, "R8 single copy after address");
      drain("R8 clear drained");

      // reset mid expansion
      send(1'b1, 8'h40, "R4");
      send(1'b0, 8'h77, "R9 pre-reset copies");
      repeat (2) @(posedge clk);
      do_reset();
      @(negedge clk);
      check(in_ready === 1'b1 && wr_en === 1'b0, "R9 expansion aborted", {in_ready, wr_en}, 2);
      repeat (3) begin
         @(negedge clk);
         check(wr_en === 1'b0, "R9 no stray copies", wr_en, 0);
      end
      send(1'b0, 8'h12, "R9 single copy after reset");
      drain("R9 post reset drained");

      // reset discards pending count
      send(1'b1, 8'h05, "R4");
      do_reset();
      send(1'b0, 8'h34, "R9 pending cleared");
      drain("R9 pending drained");

      repeat (3) @(posedge clk);
      finish_run();
   end
endmodule